// File: doc/BRIEF.md
# Masked I2C Slave Address Matcher

This block sits behind the bit-level receiver of an I2C slave. Each address byte arrives already deserialized, marked by a one-cycle strobe. The block compares the byte with a programmed own address and decides whether the slave acknowledges it. A five-bit mask field turns selected own-address bits into don't-care positions, so one slave can answer to a group of aliased addresses. When an address matches, the block raises an acknowledge decision and an interrupt pulse. It also stores the byte it actually received, so software can tell which alias was used.

Two addressing modes are supported. In 7-bit mode a single byte decides the match. In 10-bit mode a header byte carries the two upper address bits and must match exactly. The low address byte then follows and is compared under the mask. In that mode the lowest mask bit covers the two least significant address bits together. A separate start indication abandons any half-finished 10-bit sequence.

Top module: `i2c_addr_matcher`

## Requirements
- R1: While rst_n is low and after its release, ack and irq are 0, rx_buf is 00h and match_state is 00 (idle).
- R2: In 7-bit mode (mode_10bit=0), a byte with addr_valid hits when its bits [7:1] equal own_addr[7:1] at every position not masked. Bit 0 is the read/write flag and is never compared. mask_bits[i] for i = 1..5 makes bit i a don't-care. Bits 7 and 6 are always compared.
- R3: On a hit, ack and irq are both 1 during exactly the one clock cycle that follows the sampling edge. At every other time they are 0, including after a miss and after a header-only match.
- R4: On a hit, rx_buf is loaded with the received byte (in 10-bit mode, the low address byte). At all other times it keeps its value.
- R5: With mask_bits = 00000, a 7-bit byte hits only if bits [7:1] equal own_addr[7:1] exactly.
- R6: In 10-bit mode, a byte received while match_state is not 01 is a header. Its bits [7:1] must equal {11110, own_addr[9:8]}, and the mask never applies to it. A matching header sets match_state to 01 and gives no ack. A mismatching header sets it to 00.
- R7: In 10-bit mode, a byte received while match_state is 01 is compared with own_addr[7:0]. Here mask_bits[5:2] mask bits 5..2, mask_bits[1] masks bits 1 and 0 together, and bits 7 and 6 are always compared. A hit gives ack; a miss returns match_state to 00.
- R8: With own address A0h and mask 00111, the 7-bit even bytes that hit are exactly A0h, A2h, …, AEh (8 values). In 10-bit mode the low bytes that hit are exactly A0h through AFh (16 values).
- R9: start_det returns the sequencer to idle. An addr_valid in the same cycle is then handled as the first byte of a new transfer.
- R10: match_state encodes 00 as idle, 01 as header matched and waiting for the low byte, and 10 as address matched. Any hit moves it to 10 and any miss moves it to 00. Without addr_valid or start_det it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | One-cycle indication of a new START condition |
| addr_valid | input | 1 | Strobe: addr_byte holds a received address byte |
| addr_byte | input | 8 | Received address byte, bit 0 is the read/write flag |
| mode_10bit | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Programmed own address; 7-bit mode uses bits [7:1] |
| mask_bits | input | 5 | Don't-care mask, indexed [5:1] |
| ack | output | 1 | Acknowledge decision, one cycle per hit |
| irq | output | 1 | Interrupt pulse, one cycle per hit |
| rx_buf | output | 8 | Last matched address byte |
| match_state | output | 2 | Sequencer state (00 idle, 01 waiting low byte, 10 matched) |

## Verification
The assertions assume that own_addr, mask_bits and mode_10bit stay constant during the cycle that samples an address byte. They also assume that addr_byte is valid whenever addr_valid is high. The stimulus meets this by driving every input on the falling clock edge and changing the configuration only between bytes. A 10-bit header and its low byte are always sent under the same mode setting, so the header-first rule checked on ack is based on a consistent mode.

// File: rtl/i2c_amatch_pkg.sv
package i2c_amatch_pkg;
  localparam int BYTE_W = 8;
  localparam int MASK_HI = 5;
  localparam int OWN_W = 10;
  localparam int HDR_W = 5;
  localparam logic [HDR_W-1:0] HDR_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    MS_IDLE    = 2'b00,
    MS_WAIT_LO = 2'b01,
    MS_MATCHED = 2'b10
  } match_state_e;

  // Expected header byte (read/write position left 0) for the upper own bits
  function automatic logic [BYTE_W-1:0] header_pattern(input logic [1:0] own_hi);
    return {HDR_PREFIX, own_hi, 1'b0};
  endfunction

  // Equality restricted to the positions marked in care
  function automatic logic masked_eq(input logic [BYTE_W-1:0] a,
                                     input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] care);
    return ((a ^ b) & care) == '0;
  endfunction
endpackage

// File: rtl/amatch_care_gen.sv
module amatch_care_gen #(
  parameter int W  = 8,
  parameter int MH = 5
) (
  input  logic [MH:1]  mask_bits,
  output logic [W-1:0] care_7b,
  output logic [W-1:0] care_10b
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == 0) begin : g_lsb
      // 7-bit: bit 0 is read/write, never compared; 10-bit: shares mask bit 1
      assign care_7b[g]  = 1'b0;
      assign care_10b[g] = ~mask_bits[1];
    end else if (g <= MH) begin : g_masked
      assign care_7b[g]  = ~mask_bits[g];
      assign care_10b[g] = ~mask_bits[g];
    end else begin : g_fixed
      assign care_7b[g]  = 1'b1;
      assign care_10b[g] = 1'b1;
    end
  end
endmodule

// File: rtl/amatch_cmp.sv
module amatch_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] ref_byte,
  input  logic [W-1:0] care,
  output logic         equal
);
  logic [W-1:0] diff;
  for (genvar g = 0; g < W; g++) begin : g_diff
    assign diff[g] = (rx_byte[g] ^ ref_byte[g]) & care[g];
  end
  assign equal = ~|diff;
endmodule

// File: rtl/amatch_seq.sv
module amatch_seq
  import i2c_amatch_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_det,
  input  logic         addr_valid,
  input  logic         mode_10bit,
  input  logic [W-1:0] addr_byte,
  input  logic         hit_7b,
  input  logic         hit_hdr,
  input  logic         hit_lo,
  output logic         ack,
  output logic         irq,
  output logic [W-1:0] rx_buf,
  output logic [1:0]   match_state,
  output logic         hit_evt
);
  match_state_e st_q, st_base, st_nxt;
  logic         ack_q, irq_q;
  logic [W-1:0] rx_q;

  always_comb begin
    st_base = start_det ? MS_IDLE : st_q;
    st_nxt  = st_base;
    hit_evt = 1'b0;
    if (addr_valid) begin
      if (!mode_10bit) begin
        hit_evt = hit_7b;
        st_nxt  = hit_7b ? MS_MATCHED : MS_IDLE;
      end else if (st_base == MS_WAIT_LO) begin
        hit_evt = hit_lo;
        st_nxt  = hit_lo ? MS_MATCHED : MS_IDLE;
      end else begin
        st_nxt  = hit_hdr ? MS_WAIT_LO : MS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_IDLE;
      ack_q <= 1'b0;
      irq_q <= 1'b0;
      rx_q  <= '0;
    end else begin
      st_q  <= st_nxt;
      ack_q <= hit_evt;
      irq_q <= hit_evt;
      if (hit_evt) rx_q <= addr_byte;
    end
  end

  assign ack         = ack_q;
  assign irq         = irq_q;
  assign rx_buf      = rx_q;
  assign match_state = st_q;
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_amatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              addr_valid,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              mode_10bit,
  input  logic [OWN_W-1:0]  own_addr,
  input  logic [MASK_HI:1]  mask_bits,
  output logic              ack,
  output logic              irq,
  output logic [BYTE_W-1:0] rx_buf,
  output logic [1:0]        match_state
);
  localparam logic [BYTE_W-1:0] HDR_CARE = {{(BYTE_W-1){1'b1}}, 1'b0};

  logic [BYTE_W-1:0] care_7b, care_10b;
  logic [BYTE_W-1:0] ref_7b, ref_hdr, ref_lo;
  logic              hit_7b, hit_hdr, hit_lo, hit_evt;

  assign ref_7b  = {own_addr[BYTE_W-1:1], 1'b0};
  assign ref_hdr = header_pattern(own_addr[OWN_W-1:BYTE_W]);
  assign ref_lo  = own_addr[BYTE_W-1:0];

  amatch_care_gen #(.W(BYTE_W), .MH(MASK_HI)) u_care (
    .mask_bits(mask_bits), .care_7b(care_7b), .care_10b(care_10b)
  );

  amatch_cmp #(.W(BYTE_W)) u_cmp_7b (
    .rx_byte(addr_byte), .ref_byte(ref_7b), .care(care_7b), .equal(hit_7b)
  );

  amatch_cmp #(.W(BYTE_W)) u_cmp_hdr (
    .rx_byte(addr_byte), .ref_byte(ref_hdr), .care(HDR_CARE), .equal(hit_hdr)
  );

  amatch_cmp #(.W(BYTE_W)) u_cmp_lo (
    .rx_byte(addr_byte), .ref_byte(ref_lo), .care(care_10b), .equal(hit_lo)
  );

  amatch_seq #(.W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .addr_valid(addr_valid),
    .mode_10bit(mode_10bit), .addr_byte(addr_byte),
    .hit_7b(hit_7b), .hit_hdr(hit_hdr), .hit_lo(hit_lo),
    .ack(ack), .irq(irq), .rx_buf(rx_buf), .match_state(match_state),
    .hit_evt(hit_evt)
  );
endmodule

// File: rtl/amatch_chk.sv
module amatch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       addr_valid,
  input logic [7:0] addr_byte,
  input logic       mode_10bit,
  input logic [9:0] own_addr,
  input logic [5:1] mask_bits,
  input logic       ack,
  input logic       irq,
  input logic [7:0] rx_buf,
  input logic [1:0] match_state
);
  AST_ACK_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(addr_valid)); // R3
  AST_IRQ_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack == irq); // R3
  AST_RXBUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> rx_buf == $past(addr_byte)); // R4
  AST_RXBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> $stable(rx_buf)); // R4
  AST_TOP_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> rx_buf[7:6] == $past(own_addr[7:6])); // R7
  AST_EXACT_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !$past(mode_10bit) && $past(mask_bits) == 5'b0)
      |-> rx_buf[7:1] == $past(own_addr[7:1])); // R5
  AST_TEN_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(mode_10bit))
      |-> ($past(match_state) == 2'b01 && !$past(start_det))); // R6
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    match_state != 2'b11); // R10
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(addr_valid) && !$past(start_det)) |-> $stable(match_state)); // R10
  AST_MATCHED_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> match_state == 2'b10); // R10
endmodule

bind i2c_addr_matcher amatch_chk u_chk (.*);

// File: tb/tb_i2c_addr_matcher.sv
module tb_i2c_addr_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_det = 1'b0;
  logic       addr_valid = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic       mode_10bit = 1'b0;
  logic [9:0] own_addr = 10'h000;
  logic [5:1] mask_bits = 5'b0;
  logic       ack, irq;
  logic [7:0] rx_buf;
  logic [1:0] match_state;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [1:0] m_state = 2'b00;
  logic [7:0] m_rx = 8'h00;
  logic       m_hit = 1'b0;

  always #5 clk = ~clk;

  i2c_addr_matcher dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .addr_valid(addr_valid),
    .addr_byte(addr_byte), .mode_10bit(mode_10bit), .own_addr(own_addr),
    .mask_bits(mask_bits), .ack(ack), .irq(irq), .rx_buf(rx_buf),
    .match_state(match_state)
  );

  function automatic bit ref_match7(input logic [7:0] b, input logic [9:0] own,
                                    input logic [5:1] m);
    for (int i = 1; i < 8; i++) begin
      bit dc = (i <= 5) ? m[i] : 1'b0;
      if (!dc && b[i] != own[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit ref_match_lo(input logic [7:0] b, input logic [9:0] own,
                                      input logic [5:1] m);
    for (int i = 0; i < 8; i++) begin
      bit dc = (i <= 1) ? m[1] : ((i <= 5) ? m[i] : 1'b0);
      if (!dc && b[i] != own[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit ref_header(input logic [7:0] b, input logic [9:0] own);
    return (b[7:3] == 5'b11110) && (b[2:1] == own[9:8]);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] b, input logic st, input logic v);
    m_hit = 1'b0;
    if (st) m_state = 2'b00;
    if (v) begin
      if (!mode_10bit) begin
        m_hit = ref_match7(b, own_addr, mask_bits);
        m_state = m_hit ? 2'b10 : 2'b00;
      end else if (m_state == 2'b01) begin
        m_hit = ref_match_lo(b, own_addr, mask_bits);
        m_state = m_hit ? 2'b10 : 2'b00;
      end else begin
        m_state = ref_header(b, own_addr) ? 2'b01 : 2'b00;
      end
      if (m_hit) m_rx = b;
    end
  endtask

  // Drive one cycle of stimulus, then check outputs one cycle later
  task automatic step(input logic [7:0] b, input logic st, input logic v,
                      input string req);
    @(negedge clk);
    addr_byte = b; start_det = st; addr_valid = v;
    model(b, st, v);
    @(negedge clk);
    addr_valid = 1'b0; start_det = 1'b0;
    check(ack == m_hit, {req, " ack"}, ack, m_hit);
    check(irq == m_hit, {req, " irq"}, irq, m_hit);
    check(rx_buf == m_rx, {req, " rx_buf"}, rx_buf, m_rx);
    check(match_state == m_state, {req, " match_state"}, match_state, m_state);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int n_ack;
    void'($urandom(32'h5A17));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ack == 0 && irq == 0, "R1 ack/irq in reset", {ack, irq}, 0);
    check(rx_buf == 8'h00, "R1 rx_buf in reset", rx_buf, 0);
    check(match_state == 2'b00, "R1 state in reset", match_state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ack == 0 && match_state == 2'b00, "R1 after release", {ack, match_state}, 0);

    // R8: 7-bit alias example, even bytes only
    mode_10bit = 1'b0; own_addr = 10'h0A0; mask_bits = 5'b00111;
    n_ack = 0;
    for (int a = 0; a < 128; a++) begin
      step({a[6:0], 1'b0}, 1'b0, 1'b1, "R8 7b sweep");
      if (ack) begin
        n_ack++;
        check(rx_buf[7:4] == 4'hA && rx_buf[0] == 0, "R8 7b alias value", rx_buf, 8'hA0);
      end
    end
    check(n_ack == 8, "R8 7b alias count", n_ack, 8);

    // R3: ack lasts one cycle; quiet cycle keeps outputs
    step(8'hA4, 1'b0, 1'b1, "R3 hit");
    @(negedge clk);
    check(ack == 0 && irq == 0, "R3 pulse ends", {ack, irq}, 0);
    check(rx_buf == 8'hA4 && match_state == 2'b10, "R4 R10 hold when idle",
          {rx_buf, match_state}, {8'hA4, 2'b10});
    // R2: read/write bit ignored
    step(8'hA9, 1'b0, 1'b1, "R2 rw bit ignored");
    // R2: bit 6 always compared even with full mask
    mask_bits = 5'b11111;
    step(8'hE0, 1'b0, 1'b1, "R2 bit6 compared");
    step(8'h80, 1'b0, 1'b1, "R2 bit5 miss compared no");
    step(8'hBE, 1'b0, 1'b1, "R2 full mask hit");

    // R2 R5: sweep all 7-bit addresses under several masks
    for (int k = 0; k < 5; k++) begin
      own_addr = {2'b00, 8'($urandom)};
      case (k)
        0: mask_bits = 5'b00000;
        1: mask_bits = 5'b10101;
        2: mask_bits = 5'b00011;
        3: mask_bits = 5'b11000;
        default: mask_bits = 5'($urandom);
      endcase
      for (int a = 0; a < 128; a++)
        step({a[6:0], 1'($urandom)}, 1'b0, 1'b1, k == 0 ? "R5 exact sweep" : "R2 masked sweep");
    end
    mask_bits = 5'b00000; own_addr = 10'h03C;
    n_ack = 0;
    for (int a = 0; a < 128; a++) begin
      step({a[6:0], 1'b0}, 1'b0, 1'b1, "R5 exact unique");
      if (ack) n_ack++;
    end
    check(n_ack == 1, "R5 single exact hit", n_ack, 1);

    // R8 R7: 10-bit alias example, low bytes A0..AF
    mode_10bit = 1'b1; own_addr = 10'h2A0; mask_bits = 5'b00111;
    n_ack = 0;
    for (int a = 0; a < 256; a++) begin
      step(8'hF4, 1'b1, 1'b1, "R6 header");
      step(a[7:0], 1'b0, 1'b1, "R7 low byte sweep");
      if (ack) begin
        n_ack++;
        check(rx_buf[7:4] == 4'hA, "R8 10b alias value", rx_buf, 8'hA0);
      end
    end
    check(n_ack == 16, "R8 10b alias count", n_ack, 16);

    // R6: header mask independence and header-only gives no ack
    mask_bits = 5'b11111;
    step(8'hF0, 1'b1, 1'b1, "R6 wrong upper bits");
    step(8'hA0, 1'b0, 1'b1, "R6 low after bad header");
    step(8'hF5, 1'b1, 1'b1, "R6 header rw ignored");
    // R9: start abandons the wait, same-cycle byte is a header
    step(8'hA0, 1'b1, 1'b1, "R9 start with byte");
    step(8'hF4, 1'b1, 1'b1, "R6 header again");
    step(8'h00, 1'b1, 1'b0, "R9 start alone");
    step(8'hA3, 1'b0, 1'b1, "R9 low after start");
    // R7: mask bit 1 covers bits 1 and 0, bits 7..6 kept
    mask_bits = 5'b00001; own_addr = 10'h15C;
    step(8'hF2, 1'b1, 1'b1, "R6 header");
    step(8'h5F, 1'b0, 1'b1, "R7 mask1 pair");
    step(8'hF2, 1'b1, 1'b1, "R6 header");
    step(8'h9C, 1'b0, 1'b1, "R7 top bits kept");

    // Random mix of modes, configs and starts
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b;
      int sel;
      if (i % 40 == 0) begin
        own_addr = 10'($urandom); mask_bits = 5'($urandom);
        mode_10bit = 1'($urandom);
      end
      sel = $urandom_range(0, 9);
      if (sel < 3) b = {5'b11110, own_addr[9:8], 1'($urandom)};
      else if (sel < 7) b = own_addr[7:0] ^ (8'($urandom) & {2'b00, 6'h3F});
      else b = 8'($urandom);
      step(b, ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) != 0),
           mode_10bit ? "R7 R6 R10 random" : "R2 R4 R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule